// File: doc/BRIEF.md
# Zero-Page Indirect Pointer Sequencer

This block drives the bus cycles of the two pointer-based addressing modes of an 8-bit processor core. After the opcode has been fetched elsewhere, the sequencer reads the single operand byte that follows the opcode. It then fetches a 16-bit pointer from page zero, forms the effective address and performs the operand access. In pre-indexed mode the X value is added to the operand byte to find the pointer. In post-indexed mode the pointer is read directly and the Y value is added to the address it holds. Decoding, arithmetic on the operand and index register updates belong to other blocks.

The memory port is simple. The sequencer drives `addr` with a read or write strobe for one cycle. Read data on `rdata` is captured at the clock edge that ends that cycle. The cycle in which `start` is accepted counts as cycle 1, the opcode cycle, and the sequencer drives its first address in cycle 2. `done` marks the operand cycle, and the effective address and the page-crossing flag are presented alongside it.

Top module: `zp_ptr_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `rd_en`, `wr_en` and `done` are 0.
- R2: Pre-indexed (`mode_post`=0) reads addresses in this order: cycle 2 reads `pc_in`, cycle 3 reads {00,B} and discards the data, cycle 4 reads {00,B+X}, cycle 5 reads {00,B+X+1}, and cycle 6 accesses {H,L}. Here B is the byte read in cycle 2, L is the byte read in cycle 4 and H is the byte read in cycle 5. `done` is high only in cycle 6.
- R3: The pre-indexed pointer address B+X is taken modulo 256, so it always stays in page zero.
- R4: In both modes, the pointer high byte is read at the pointer address plus one, taken modulo 256. A pointer at FF takes its high byte from 0000.
- R5: For a post-indexed read whose L+Y does not exceed 255, the sequence is: cycle 2 reads `pc_in`, cycle 3 reads {00,P}, cycle 4 reads {00,P+1}, and cycle 5 accesses {H,L+Y} with `done`. `page_crossed` is 0.
- R6: For a post-indexed access whose L+Y exceeds 255, cycle 5 reads {H,(L+Y) mod 256} and discards the data. Cycle 6 accesses {H+1,(L+Y) mod 256}, with H+1 taken modulo 256, and `done` is raised. `page_crossed` is 1.
- R7: A post-indexed write always takes 6 cycles. Cycle 5 is a read of {H,(L+Y) mod 256}, and the write happens only in cycle 6. `page_crossed` reflects the carry.
- R8: A pre-indexed write raises `wr_en` only in cycle 6. Every earlier cycle is a read.
- R9: `pc_next` equals `pc_in`+1 while `done` is high. The instruction is two bytes long.
- R10: X, Y, `mode_post`, `is_write` and `pc_in` are sampled only when `start` is accepted. `start` is ignored while `busy` is 1, and changing the index inputs during a sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode cycle marker, accepted when idle |
| mode_post | input | 1 | 0 = pre-indexed with X, 1 = post-indexed with Y |
| is_write | input | 1 | Operand access is a write |
| pc_in | input | 16 | Address of the byte after the opcode |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rdata | input | 8 | Read data for the current cycle |
| addr | output | 16 | Bus address |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Operand access cycle |
| eff_addr | output | 16 | Effective address, valid with done |
| page_crossed | output | 1 | Post-index carry, valid with done |
| pc_next | output | 16 | Program counter past the pointer byte |

## Verification
The assertions assume that `rdata` holds a defined byte in every cycle the sequencer reads. They also assume that `start` is a clean single-cycle pulse, driven away from the clock edge. The bench's memory model returns a computed byte for every address, with overrides placed at the pointer locations, so every read is defined. The bench raises `start` for exactly one cycle per instruction, except for one deliberate re-assertion that is made while the sequencer is busy.

// File: rtl/zps_pkg.sv
package zps_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPND, ST_ZPDUM, ST_PLO, ST_PHI, ST_FIX, ST_OPER
  } zps_state_e;

  // byte addition that wraps inside one page
  function automatic logic [BYTE_W-1:0] page_add(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    return a + b;
  endfunction

  // index addition with carry out in the top bit
  function automatic logic [BYTE_W:0] idx_add(input logic [BYTE_W-1:0] lo,
                                              input logic [BYTE_W-1:0] idx);
    return {1'b0, lo} + {1'b0, idx};
  endfunction
endpackage

// File: rtl/zps_ctrl.sv
module zps_ctrl
  import zps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_acc,
  input  logic       mode_in,
  input  logic       wr_in,
  input  logic       carry_now,
  output zps_state_e state,
  output logic       mode_q,
  output logic       wr_q,
  output logic       zp_phase
);
  zps_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_acc) nxt = ST_OPND;
      ST_OPND:  nxt = mode_q ? ST_PLO : ST_ZPDUM;
      ST_ZPDUM: nxt = ST_PLO;
      ST_PLO:   nxt = ST_PHI;
      ST_PHI:   nxt = (mode_q && (wr_q || carry_now)) ? ST_FIX : ST_OPER;
      ST_FIX:   nxt = ST_OPER;
      ST_OPER:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      state <= nxt;
      if (start_acc) begin
        mode_q <= mode_in;
        wr_q   <= wr_in;
      end
    end
  end

  assign zp_phase = (state == ST_ZPDUM) || (state == ST_PLO) || (state == ST_PHI);

  // post-indexed writes always take the corrective cycle
  a_r7_write_takes_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PHI && mode_q && wr_q) |=> (state == ST_FIX));
  // the dummy page-zero cycle belongs to pre-indexed mode only
  a_r2_dummy_pre_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ZPDUM) |-> !mode_q);
endmodule

// File: rtl/zps_dpath.sv
module zps_dpath
  import zps_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          mode_in,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] rdata,
  input  zps_state_e    state,
  input  logic          mode_q,
  output logic [AW-1:0] addr,
  output logic          carry_now,
  output logic          carry_q,
  output logic [AW-1:0] pc_next
);
  logic [AW-1:0] pc_q;
  logic [DW-1:0] idx_q, zp_q, lo_q, hi_q;
  logic [DW:0]   sum_w;

  assign sum_w     = idx_add(lo_q, idx_q);
  assign carry_now = sum_w[DW];
  assign pc_next   = pc_q + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      idx_q   <= '0;
      zp_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      if (start_acc) begin
        pc_q    <= pc_in;
        idx_q   <= mode_in ? idx_y : idx_x;
        carry_q <= 1'b0;
      end
      unique case (state)
        ST_OPND:  zp_q <= rdata;
        ST_ZPDUM: zp_q <= page_add(zp_q, idx_q);
        ST_PLO:   lo_q <= rdata;
        ST_PHI: begin
          hi_q <= rdata;
          if (mode_q) begin
            lo_q    <= sum_w[DW-1:0];
            carry_q <= sum_w[DW];
          end
        end
        ST_FIX:   hi_q <= page_add(hi_q, {{(DW-1){1'b0}}, carry_q});
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_OPND:          addr = pc_q;
      ST_ZPDUM, ST_PLO: addr = {{DW{1'b0}}, zp_q};
      ST_PHI:           addr = {{DW{1'b0}}, page_add(zp_q, {{(DW-1){1'b0}}, 1'b1})};
      ST_FIX, ST_OPER:  addr = {hi_q, lo_q};
      default:          addr = '0;
    endcase
  end

  // the pointer high byte comes from the next page-zero location, wrapping
  a_r4_ptr_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PHI) |-> (addr[DW-1:0] == DW'($past(addr[DW-1:0]) + DW'(1))));
endmodule

// File: rtl/zp_ptr_seq.sv
module zp_ptr_seq
  import zps_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_post,
  input  logic          is_write,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic          rd_en,
  output logic          wr_en,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic          page_crossed,
  output logic [AW-1:0] pc_next
);
  zps_state_e state;
  logic mode_q, wr_q, zp_phase, carry_now, carry_q, start_acc;

  assign start_acc = start && (state == ST_IDLE);

  zps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .mode_in(mode_post),
    .wr_in(is_write), .carry_now(carry_now), .state(state), .mode_q(mode_q),
    .wr_q(wr_q), .zp_phase(zp_phase)
  );

  zps_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .mode_in(mode_post),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .rdata(rdata), .state(state),
    .mode_q(mode_q), .addr(addr), .carry_now(carry_now), .carry_q(carry_q),
    .pc_next(pc_next)
  );

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_OPER);
  assign wr_en        = done && wr_q;
  assign rd_en        = busy && !wr_en;
  assign eff_addr     = done ? addr : '0;
  assign page_crossed = done && carry_q;

  // page-zero cycles never carry into page one
  a_r3_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    zp_phase |-> (addr[AW-1:DW] == '0));
  // pre-indexed operand lands in cycle 6
  a_r2_pre_six: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !mode_post) |-> ##5 done);
  // post-indexed read without carry finishes in cycle 5
  a_r5_post_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q && !wr_q && !page_crossed) |-> $past(start_acc, 4));
  // a carry costs exactly one cycle
  a_r6_cross_six: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_crossed) |-> $past(start_acc, 5));
  // a write is preceded by a read cycle in the same sequence
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));
  // the program counter result does not move while busy
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pc_next));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en}) && (busy || !(rd_en || done)));
endmodule

// File: tb/sim_zp_ptr_seq.sv
`timescale 1ns/1ps
module sim_zp_ptr_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_post = 1'b0, is_write = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  idx_x = '0, idx_y = '0, rdata;
  logic [15:0] addr, eff_addr, pc_next;
  logic rd_en, wr_en, busy, done, page_crossed;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  zp_ptr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_post(mode_post), .is_write(is_write),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .rdata(rdata), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .busy(busy), .done(done), .eff_addr(eff_addr),
    .page_crossed(page_crossed), .pc_next(pc_next)
  );

  // memory model: computed content with a few overrides
  logic [15:0] ov_a [4];
  logic [7:0]  ov_d [4];
  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] ^ a[15:8] ^ 8'hA5;
    for (int i = 0; i < 4; i++) if (ov_a[i] == a) r = ov_d[i];
    return r;
  endfunction
  always_comb rdata = mem_rd(addr);

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: mode(4) wr(4) pc(16) opnd(8) idx(8) lo(8) hi(8)
  localparam logic [55:0] VEC [10] = '{
    56'h0_0_0300_20_04_34_12,  // R2 pre read
    56'h0_0_0410_F7_10_00_80,  // R3 pre wrap F7+10 -> 07
    56'h0_0_0520_F0_0F_11_22,  // R4 pre pointer at FF
    56'h0_1_0630_40_00_CD_AB,  // R8 pre write
    56'h1_0_0740_50_05_10_30,  // R5 post read no carry
    56'h1_0_0850_60_20_F0_30,  // R6 post read carry
    56'h1_1_0960_70_01_00_44,  // R7 post write no carry
    56'h1_0_0A70_FF_00_02_05,  // R4 post pointer at FF
    56'h1_0_0B80_C0_80_80_FF,  // R6 high byte wraps to 00
    56'h1_1_0C90_90_FF_01_20   // R7 post write carry
  };

  task automatic run_vec(input logic [55:0] v, input bit poke, input string tag);
    logic m, w, cy;
    logic [15:0] pc, ea;
    logic [7:0] op, ix, lo, hi, p;
    logic [8:0] s;
    logic [15:0] ea_a [8];
    logic        ea_w [8];
    int len;
    m = v[52]; w = v[48]; pc = v[47:32]; op = v[31:24]; ix = v[23:16]; lo = v[15:8]; hi = v[7:0];
    p = m ? op : 8'(op + ix);
    ov_a[0] = pc;                ov_d[0] = op;
    ov_a[1] = {8'h00, p};        ov_d[1] = lo;
    ov_a[2] = {8'h00, 8'(p + 8'd1)}; ov_d[2] = hi;
    ov_a[3] = 16'hFFFF;          ov_d[3] = 8'h00;
    for (int k = 0; k < 8; k++) begin ea_a[k] = '0; ea_w[k] = 1'b0; end
    ea_a[2] = pc;
    cy = 1'b0;
    if (!m) begin
      ea_a[3] = {8'h00, op}; ea_a[4] = {8'h00, p}; ea_a[5] = {8'h00, 8'(p + 8'd1)};
      ea = {hi, lo}; ea_a[6] = ea; ea_w[6] = w; len = 6;
    end else begin
      s = {1'b0, lo} + {1'b0, ix}; cy = s[8];
      ea_a[3] = {8'h00, p}; ea_a[4] = {8'h00, 8'(p + 8'd1)};
      ea_a[5] = {hi, s[7:0]};
      if (!cy && !w) begin ea = ea_a[5]; len = 5; end
      else begin ea = {8'(hi + {7'b0, cy}), s[7:0]}; ea_a[6] = ea; ea_w[6] = w; len = 6; end
    end
    @(negedge clk);
    start = 1'b1; mode_post = m; is_write = w; pc_in = pc;
    idx_x = m ? ~ix : ix; idx_y = m ? ix : ~ix;
    for (int k = 2; k <= len + 1; k++) begin
      @(negedge clk);
      start = (poke && k == 3);
      idx_x = 8'h99; idx_y = 8'h99; mode_post = ~m; is_write = ~w; pc_in = 16'hDEAD;
      if (k <= len)
        chk({addr, rd_en, wr_en, done} == {ea_a[k], !ea_w[k], ea_w[k], k == len},
            $sformatf("%s cycle %0d addr/rd/wr/done", tag, k),
            {addr, rd_en, wr_en, done}, {ea_a[k], !ea_w[k], ea_w[k], 1'(k == len)});
      if (k == len) begin
        chk(eff_addr == ea && page_crossed == cy, {tag, " R6 eff_addr/page_crossed"},
            {eff_addr, page_crossed}, {ea, cy});
        chk(pc_next == 16'(pc + 16'd1), {tag, " R9 pc_next"}, pc_next, 16'(pc + 16'd1));
      end
      if (k == len + 1)
        chk(!busy && !rd_en && !wr_en && !done, {tag, " R1 idle after"},
            {busy, rd_en, wr_en, done}, 4'b0);
    end
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ov_a[i] = 16'hFFFF; ov_d[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(!busy && !rd_en && !wr_en && !done, "R1 reset state", {busy, rd_en, wr_en, done}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 2'b0);
    for (int i = 0; i < 10; i++) run_vec(VEC[i], 1'b0, $sformatf("vec%0d", i));
    // R10: start re-asserted while busy, index inputs scrambled mid-sequence
    run_vec(VEC[5], 1'b1, "R10 poke post");
    run_vec(VEC[1], 1'b1, "R10 poke pre");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule